// File: doc/BRIEF.md
# Interrupt Source Latch Controller

This block drives the two interrupt lines of an 8-bit CPU board. A normal interrupt (IRQ) is raised periodically from an internal clock divider and held until software acknowledges it. A fast interrupt (FIRQ) is shared by two sources. One is a display event: a software-set target line is compared against a four-phase frame counter advanced by a frame tick. The other is a pulse from the sound board. Each source has its own latch, and software reads that latch through its own status register to find out which source fired.

The CPU reaches the block through a small register port made of an offset, write data, read and write strobes, and combinational read data. Writing the line register or the source register acknowledges FIRQ and clears the matching latch. The line-register write also loads a new target line. A write to the IRQ acknowledge offset drops IRQ. When an acknowledge and a new event land in the same cycle, the event wins, so no interrupt is lost.

Top module: `irq_source_latch`

## Requirements
- R1: After synchronous reset, `irq` and `firq` are 0, both source latches are clear and the target line is 0.
- R2: `irq` rises at the clock edge that ends each run of IRQ_DIV cycles counted from reset release. It stays high until a write to offset 3 and falls at the next edge.
- R3: Each `frame_tick` advances a frame phase counter that starts at 0 and counts modulo 4. A display event happens on a tick whose phase before the increment equals the target line divided by 8. A target of 32 or more never matches.
- R4: A display event sets `firq` and the display latch at the next edge. Reading offset 1 returns 0x80 while the display latch is set and 0x00 otherwise.
- R5: A write to offset 1 clears `firq` and the display latch, and stores the written byte as the target line. A match uses the target held before that write.
- R6: A cycle with `snd_reply` high sets `firq` and the sound latch at the next edge. Reading offset 2 returns 0x80 while the sound latch is set and 0x00 otherwise.
- R7: A write to offset 2 clears `firq` and the sound latch. The display latch is left as it was.
- R8: When an acknowledge write and a new event of either source fall in the same cycle, `firq` and that source's latch end up set.
- R9: Bits 6..0 of the status reads are 0. A read of any offset other than 1 or 2, and any cycle without `reg_rd`, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_ofs | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data, combinational |
| frame_tick | input | 1 | One-cycle frame tick |
| snd_reply | input | 1 | Sound-board reply pulse |
| irq | output | 1 | Periodic normal interrupt |
| firq | output | 1 | Shared fast interrupt |

## Verification
Every latch and interrupt line changes at the first clock edge after its cause. Read data depends only on the current state and the present offset, so a status read reflects an event or acknowledge one cycle after that stimulus was applied. The bench drives inputs just after the falling edge. It advances a behavioural model at each rising edge and compares `irq`, `firq` and `reg_rdata` against that model at the next falling edge, so each result is checked in the cycle it is due. The periodic IRQ is checked at the exact edge that closes each IRQ_DIV window.

// File: rtl/irqsl_pkg.sv
package irqsl_pkg;

    localparam int DATA_W = 8;
    localparam int OFS_W  = 3;

    localparam logic [OFS_W-1:0] OFS_LINE   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_SRC    = 3'd2;
    localparam logic [OFS_W-1:0] OFS_IRQACK = 3'd3;

    // Which acknowledge a bus write carries
    typedef struct packed {
        logic line;
        logic src;
        logic irq;
    } ack_s;

    typedef enum logic {SRC_DISP = 1'b0, SRC_SND = 1'b1} firq_src_e;

    function automatic ack_s decode_write(input logic wr, input logic [OFS_W-1:0] ofs);
        ack_s a;
        a.line = wr && (ofs == OFS_LINE);
        a.src  = wr && (ofs == OFS_SRC);
        a.irq  = wr && (ofs == OFS_IRQACK);
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] status_byte(input logic flag);
        return {flag, {(DATA_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/irqsl_tick_div.sv
module irqsl_tick_div #(
    parameter int DIV = 2048
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/irqsl_disp_match.sv
module irqsl_disp_match
    import irqsl_pkg::*;
#(
    parameter int PHASES     = 4,
    parameter int LINE_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic [DATA_W-1:0] line,
    output logic              hit
);
    localparam int PW = (PHASES > 2) ? $clog2(PHASES) : 1;
    localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

    logic [PW-1:0]     phase_q;
    logic [DATA_W-1:0] target;

    assign target = line >> LINE_SHIFT;
    assign hit    = frame_tick && ({{(DATA_W-PW){1'b0}}, phase_q} == target);

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (frame_tick)
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/irqsl_src_latch.sv
module irqsl_src_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    // A set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set | (q & ~clr);
    end
endmodule

// File: rtl/irq_source_latch.sv
module irq_source_latch
    import irqsl_pkg::*;
#(
    parameter int IRQ_DIV    = 2048,
    parameter int PHASES     = 4,
    parameter int LINE_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  reg_ofs,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              frame_tick,
    input  logic              snd_reply,
    output logic              irq,
    output logic              firq
);
    localparam int NSRC = 2;

    ack_s              ack;
    logic              irq_tick;
    logic              disp_hit;
    logic [DATA_W-1:0] line_q;
    logic [NSRC-1:0]   src_set;
    logic [NSRC-1:0]   src_clr;
    logic [NSRC-1:0]   src_q;

    assign ack = decode_write(reg_wr, reg_ofs);

    irqsl_tick_div #(.DIV(IRQ_DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .tick(irq_tick)
    );

    irqsl_disp_match #(.PHASES(PHASES), .LINE_SHIFT(LINE_SHIFT)) u_match (
        .clk       (clk),
        .rst       (rst),
        .frame_tick(frame_tick),
        .line      (line_q),
        .hit       (disp_hit)
    );

    always_ff @(posedge clk) begin
        if (rst)           line_q <= '0;
        else if (ack.line) line_q <= reg_wdata;
    end

    assign src_set[SRC_DISP] = disp_hit;
    assign src_set[SRC_SND]  = snd_reply;
    assign src_clr[SRC_DISP] = ack.line;
    assign src_clr[SRC_SND]  = ack.src;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irqsl_src_latch u_lat (
            .clk(clk),
            .rst(rst),
            .set(src_set[i]),
            .clr(src_clr[i]),
            .q  (src_q[i])
        );
    end

    irqsl_src_latch u_firq (
        .clk(clk),
        .rst(rst),
        .set(|src_set),
        .clr(ack.line | ack.src),
        .q  (firq)
    );

    irqsl_src_latch u_irq (
        .clk(clk),
        .rst(rst),
        .set(irq_tick),
        .clr(ack.irq),
        .q  (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_ofs)
                OFS_LINE: reg_rdata = status_byte(src_q[SRC_DISP]);
                OFS_SRC:  reg_rdata = status_byte(src_q[SRC_SND]);
                default:  reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqsl_checker.sv
module irqsl_checker
    import irqsl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OFS_W-1:0]  reg_ofs,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              snd_reply,
    input logic              irq,
    input logic              firq,
    input logic              irq_tick,
    input logic              disp_hit,
    input logic [1:0]        src_q
);
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !(reg_wr && reg_ofs == OFS_IRQACK)) |=> irq); // R2
    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_ofs == OFS_IRQACK && !irq_tick) |=> !irq); // R2
    AST_DISP_SETS: assert property (@(posedge clk) disable iff (rst)
        disp_hit |=> (firq && src_q[0])); // R4
    AST_LINE_ACK: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_ofs == OFS_LINE && !disp_hit) |=> !src_q[0]); // R5
    AST_SND_SETS: assert property (@(posedge clk) disable iff (rst)
        snd_reply |=> (firq && src_q[1])); // R6
    AST_SRC_ACK_KEEPS_DISP: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_ofs == OFS_SRC && !disp_hit) |=> $stable(src_q[0])); // R7
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_ofs == OFS_SRC && snd_reply) |=> firq); // R8
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[DATA_W-2:0] == '0)); // R9
    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |-> (reg_rdata == '0)); // R9
endmodule

bind irq_source_latch irqsl_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_ofs  (reg_ofs),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_rdata(reg_rdata),
    .snd_reply(snd_reply),
    .irq      (irq),
    .firq     (firq),
    .irq_tick (irq_tick),
    .disp_hit (disp_hit),
    .src_q    (src_q)
);

// File: tb/test_irq_source_latch.sv
`timescale 1ns/1ps
module test_irq_source_latch;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_ofs = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_rdata;
    logic       frame_tick = 1'b0;
    logic       snd_reply = 1'b0;
    logic       irq, firq;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    bit    started = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_div, m_frame, m_line;
    bit m_irq, m_firq, m_ld, m_ls;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_source_latch #(.IRQ_DIV(DIV)) i_irq_source_latch (
        .clk(clk), .rst(rst), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
        .frame_tick(frame_tick), .snd_reply(snd_reply), .irq(irq), .firq(firq)
    );

    always @(posedge clk) begin
        bit tick, disp, wl, ws, wa;
        started = 1;
        cycles++;
        if (rst) begin
            m_div = 0; m_frame = 0; m_line = 0;
            m_irq = 0; m_firq = 0; m_ld = 0; m_ls = 0;
        end else begin
            tick  = (m_div == DIV - 1);
            m_div = tick ? 0 : m_div + 1;
            disp  = frame_tick && ((m_frame % 4) == (m_line * 4 / 32));
            if (frame_tick) m_frame++;
            wl = reg_wr && reg_ofs == 3'd1;
            ws = reg_wr && reg_ofs == 3'd2;
            wa = reg_wr && reg_ofs == 3'd3;
            if (tick) m_irq = 1; else if (wa) m_irq = 0;
            if (disp) m_ld = 1; else if (wl) m_ld = 0;
            if (snd_reply) m_ls = 1; else if (ws) m_ls = 0;
            if (disp || snd_reply) m_firq = 1; else if (wl || ws) m_firq = 0;
            if (wl) m_line = reg_wdata;
        end
    end

    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (started) begin
            exp_rd = 8'h00;
            if (reg_rd && reg_ofs == 3'd1) exp_rd = {m_ld, 7'b0};
            if (reg_rd && reg_ofs == 3'd2) exp_rd = {m_ls, 7'b0};
            vectors++;
            if (irq !== m_irq || firq !== m_firq || reg_rdata !== exp_rd) begin
                fails++;
                $display("FAIL %s cycle %0d: irq/firq/rdata actual %0b/%0b/%02h expected %0b/%0b/%02h",
                         cur_req, cycles, irq, firq, reg_rdata, m_irq, m_firq, exp_rd);
            end
        end
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic drive(input logic [2:0] ofs, input logic [7:0] wd, input bit rd,
                         input bit wr, input bit ft, input bit snd);
        @(negedge clk); #1;
        reg_ofs = ofs; reg_wdata = wd; reg_rd = rd; reg_wr = wr;
        frame_tick = ft; snd_reply = snd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(3'd0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic frames(input int n, input logic [2:0] rofs);
        for (int i = 0; i < n; i++) begin
            drive(rofs, 8'h00, 1, 0, 1, 0);
            drive(rofs, 8'h00, 1, 0, 0, 0);
            drive(rofs, 8'h00, 1, 0, 0, 0);
        end
    endtask

    initial begin
        // R1: reset state, status reads during and after reset
        cur_req = "R1";
        drive(3'd1, 8'h00, 1, 0, 0, 0);
        drive(3'd2, 8'h00, 1, 0, 0, 0);
        rst = 1'b0;
        drive(3'd1, 8'h00, 1, 0, 0, 0);
        drive(3'd2, 8'h00, 1, 0, 0, 0);

        // R2: periodic IRQ, held, then acknowledged
        cur_req = "R2";
        idle(DIV + 5);
        drive(3'd3, 8'h00, 0, 1, 0, 0);
        idle(DIV);
        drive(3'd3, 8'h00, 0, 1, 0, 0);

        // R6 / R7: sound reply and its acknowledge
        cur_req = "R6";
        drive(3'd0, 8'h00, 0, 0, 0, 1);
        drive(3'd2, 8'h00, 1, 0, 0, 0);
        drive(3'd1, 8'h00, 1, 0, 0, 0);
        cur_req = "R7";
        drive(3'd2, 8'h00, 0, 1, 0, 0);
        drive(3'd2, 8'h00, 1, 0, 0, 0);

        // R3 / R4: target 0 then target 2 via line register
        cur_req = "R3";
        frames(5, 3'd1);
        cur_req = "R5";
        drive(3'd1, 8'h10, 0, 1, 0, 0);
        cur_req = "R4";
        frames(8, 3'd1);
        cur_req = "R7";
        drive(3'd0, 8'h00, 0, 0, 0, 1);
        drive(3'd2, 8'h00, 0, 1, 0, 0);
        drive(3'd1, 8'h00, 1, 0, 0, 0);
        cur_req = "R5";
        drive(3'd1, 8'h1F, 0, 1, 0, 0);
        drive(3'd1, 8'h00, 1, 0, 0, 0);
        frames(8, 3'd1);
        // R3: out-of-range target never fires
        cur_req = "R3";
        drive(3'd1, 8'h40, 0, 1, 0, 0);
        frames(12, 3'd1);
        drive(3'd1, 8'hFF, 0, 1, 0, 0);
        frames(8, 3'd1);

        // R8: event and acknowledge in the same cycle
        cur_req = "R8";
        drive(3'd2, 8'h00, 0, 1, 0, 1);
        drive(3'd2, 8'h00, 1, 0, 0, 0);
        drive(3'd1, 8'h08, 0, 1, 0, 0);
        for (int i = 0; i < 8; i++) begin
            drive(3'd1, 8'h08, 0, 1, 1, 0);
            drive(3'd1, 8'h00, 1, 0, 0, 0);
        end
        drive(3'd2, 8'h00, 0, 1, 0, 0);

        // R9: unused offsets and strobe-free cycles
        cur_req = "R9";
        drive(3'd0, 8'h00, 0, 0, 0, 1);
        for (int o = 0; o < 8; o++) drive(3'(o), 8'h00, 1, 0, 0, 0);
        drive(3'd2, 8'h00, 0, 0, 0, 0);
        drive(3'd3, 8'h00, 0, 1, 0, 0);
        idle(3 * DIV);

        @(negedge clk); #2;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule